// File: doc/BRIEF.md
# Clocked Slave Register Port

This block is the host-facing slave port of a peripheral's register file. A microprocessor reaches up to 256 byte-wide register locations through it. Each access runs as a fixed sequence of bus states on the bus clock: entry state T1, states T2 and T3, a stretchable final state T4, and an idle state Ti.

Chip select opens an access and latches the address and byte-high enable. The read and write strobes are sampled on the falling clock edge inside T1. Read data goes onto the bus, or write data is taken from it, on the rising edge that opens T3. The access stays in T4 for as long as the host holds its strobe low, so the host can lengthen any cycle.

The data bus is modelled as a data word plus an output enable. The wait output is low while a recognised access is in progress and high otherwise. After every access the port passes through at least one idle state before it accepts the next one.

Top module: `slv_bus_port`

## Requirements
- R1: After reset, `wait_o` is 1, `dout_oe` is 0, `dout` is 0, and every implemented register location reads as zero.
- R2: The address and byte-high enable are captured on the rising edge at which an idle port sees `cs_n` low; this edge is the entry to T1. Changes to them after that edge do not affect the access.
- R3: A read is recognised when `rd_n` is low and `wr_n` is high at the falling edge inside T1. `dout_oe` rises, and `dout` carries the read data, from the second rising edge after T1 entry (the start of T3).
- R4: While the port is in T4 and the active strobe stays low, `dout_oe`, `dout` and a low `wait_o` hold. The first rising edge in T4 that sees the strobe high ends the access: `wait_o` goes to 1, `dout_oe` to 0 and `dout` to 0 at that edge.
- R5: A write is recognised when `wr_n` is low and `rd_n` is high at the falling edge inside T1. `din` is stored at the rising edge that starts T3, and later changes to `din` are ignored.
- R6: A write ends in the same way as a read, on the first rising edge in T4 that sees `wr_n` high; `wait_o` returns to 1 there and `dout_oe` stays 0 throughout.
- R7: After an access ends, the port spends at least one idle state before the next T1. If `cs_n` is held low and a strobe is asserted again right away, the next T1 starts one edge after the end, and the next read's `dout_oe` rises three edges after the end.
- R8: Lanes follow the latched A0 and `bhe_n` (active low). With A0=0 the even byte at the word `addr[7:1]` uses `din/dout[7:0]`. With `bhe_n`=0 the odd byte of that word uses bits [15:8]. With A0=0 and `bhe_n`=0 both bytes are accessed. An access with A0=1 and `bhe_n`=1 writes nothing and reads 0. A lane that is not enabled reads as 0.
- R9: Byte addresses from IMPL_BYTES (default 192) to 255 are unimplemented: writes to them are dropped and reads return 0.
- R10: If both strobes, or neither strobe, are low at the falling edge inside T1, the port returns to idle at the next rising edge. `wait_o` stays 1, `dout_oe` stays 0 and no register changes.
- R11: `wait_o` is low from the rising edge that enters T2 until the edge that ends the access, and is high in Ti and T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; strobes are sampled on its falling edge, all else on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bhe_n | input | 1 | Byte-high enable, active low; enables the odd byte lane |
| addr | input | 8 | Byte address of the register location |
| din | input | 16 | Data bus from the host |
| dout | output | 16 | Data bus toward the host, zero when not driven |
| dout_oe | output | 1 | Output enable of the data bus |
| wait_o | output | 1 | Low while a recognised access is in progress |

## Verification
The end of one access and the start of the next can meet. When the host releases its strobe but keeps chip select low and asserts the strobe again in the following slot, the single idle state is the only thing that keeps the two accesses apart. The bench reproduces this with back-to-back accesses, both directed and random. It judges the result by checking that `wait_o` and `dout_oe` show the exact idle and T1 states before the next data phase, and that each read returns the value the reference model expects after the preceding write. Address and write data are also changed in the slot right after their capture edges, so a late capture would show up as wrong data.

// File: rtl/slv_pkg.sv
package slv_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_TI = 3'd0,
    ST_T1 = 3'd1,
    ST_T2 = 3'd2,
    ST_T3 = 3'd3,
    ST_T4 = 3'd4
  } bus_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } bus_op_e;
endpackage

// File: rtl/slv_strobe_sampler.sv
// Falling-edge capture of the strobes; the value taken inside T1 decides the access kind.
module slv_strobe_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_smp,
  output logic wr_smp
);
  logic rd_d, wr_d;

  always_comb begin
    rd_d = ~rd_n;
    wr_d = ~wr_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_smp <= 1'b0;
      wr_smp <= 1'b0;
    end else begin
      rd_smp <= rd_d;
      wr_smp <= wr_d;
    end
  end
endmodule

// File: rtl/slv_cycle_fsm.sv
// Bus-state sequencer: Ti -> T1 -> T2 -> T3 -> T4 (stretchable) -> Ti.
module slv_cycle_fsm
  import slv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       rd_smp,
  input  logic       wr_smp,
  output bus_state_e state,
  output logic       latch_en,
  output logic       rd_launch,
  output logic       wr_launch,
  output logic       cyc_end,
  output logic       wait_o,
  output logic       dout_oe
);
  bus_state_e state_q, state_d;
  bus_op_e    op_q, op_d;
  logic       wait_q, wait_d;
  logic       oe_q, oe_d;
  logic       strobe_high;

  always_comb begin
    state_d     = state_q;
    op_d        = op_q;
    latch_en    = 1'b0;
    rd_launch   = 1'b0;
    wr_launch   = 1'b0;
    cyc_end     = 1'b0;
    strobe_high = (op_q == OP_WR) ? wr_n : rd_n;
    case (state_q)
      ST_TI: begin
        if (!cs_n) begin
          state_d  = ST_T1;
          latch_en = 1'b1;
        end
      end
      ST_T1: begin
        if (rd_smp ^ wr_smp) begin
          state_d = ST_T2;
          op_d    = rd_smp ? OP_RD : OP_WR;
        end else begin
          state_d = ST_TI;
          op_d    = OP_NONE;
        end
      end
      ST_T2: begin
        state_d   = ST_T3;
        rd_launch = (op_q == OP_RD);
        wr_launch = (op_q == OP_WR);
      end
      ST_T3: state_d = ST_T4;
      ST_T4: begin
        if (strobe_high) begin
          state_d = ST_TI;
          op_d    = OP_NONE;
          cyc_end = 1'b1;
        end
      end
      default: begin
        state_d = ST_TI;
        op_d    = OP_NONE;
      end
    endcase
  end

  always_comb begin
    wait_d = wait_q;
    oe_d   = oe_q;
    if (state_q == ST_T1 && state_d == ST_T2) wait_d = 1'b0;
    if (rd_launch) oe_d = 1'b1;
    if (cyc_end) begin
      wait_d = 1'b1;
      oe_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TI;
      op_q    <= OP_NONE;
      wait_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      wait_q  <= wait_d;
      oe_q    <= oe_d;
    end
  end

  assign state   = state_q;
  assign wait_o  = wait_q;
  assign dout_oe = oe_q;
endmodule

// File: rtl/slv_regfile.sv
// Byte-lane register storage; only the implemented words get flops.
module slv_regfile #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned IMPL_BYTES = 192
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-2:0]         word_idx,
  input  logic [1:0]                lane_en,
  input  logic [slv_pkg::BUS_W-1:0] wdata,
  output logic [slv_pkg::BUS_W-1:0] rdata
);
  localparam int unsigned LANES = slv_pkg::BUS_W / slv_pkg::BYTE_W;
  localparam int unsigned WORDS = IMPL_BYTES / LANES;
  localparam int unsigned IDX_W = ADDR_W - 1;
  localparam int unsigned BW    = slv_pkg::BYTE_W;

  logic [WORDS*slv_pkg::BUS_W-1:0] store_flat;
  logic [slv_pkg::BUS_W-1:0]       word_sel;
  logic                            in_range;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BW-1:0] byte_q;
      logic          byte_en;
      assign byte_en = wr_en && (word_idx == IDX_W'(w)) && lane_en[l];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= '0;
        else if (byte_en) byte_q <= wdata[l*BW +: BW];
      end
      assign store_flat[(w*LANES+l)*BW +: BW] = byte_q;
    end
  end

  always_comb begin
    word_sel = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (word_idx == IDX_W'(w)) word_sel = store_flat[w*slv_pkg::BUS_W +: slv_pkg::BUS_W];
    end
  end

  assign in_range = (32'(word_idx) < WORDS);

  always_comb begin
    rdata = '0;
    for (int l = 0; l < LANES; l++) begin
      if (in_range && lane_en[l]) rdata[l*BW +: BW] = word_sel[l*BW +: BW];
    end
  end
endmodule

// File: rtl/slv_bus_port.sv
module slv_bus_port
  import slv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned IMPL_BYTES = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bhe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic              dout_oe,
  output logic              wait_o
);
  logic              rst_meta, rst_sync;
  logic              rd_smp, wr_smp;
  bus_state_e        state;
  logic              latch_en, rd_launch, wr_launch, cyc_end;
  logic [ADDR_W-1:0] addr_q;
  logic              bhe_q;
  logic [1:0]        lane_en;
  logic [BUS_W-1:0]  rf_rdata;
  logic [BUS_W-1:0]  dout_q, dout_d;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  slv_strobe_sampler u_smp (
    .clk    (clk),
    .rst_n  (rst_sync),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .rd_smp (rd_smp),
    .wr_smp (wr_smp)
  );

  slv_cycle_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rd_smp    (rd_smp),
    .wr_smp    (wr_smp),
    .state     (state),
    .latch_en  (latch_en),
    .rd_launch (rd_launch),
    .wr_launch (wr_launch),
    .cyc_end   (cyc_end),
    .wait_o    (wait_o),
    .dout_oe   (dout_oe)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      addr_q <= '0;
      bhe_q  <= 1'b1;
    end else if (latch_en) begin
      addr_q <= addr;
      bhe_q  <= bhe_n;
    end
  end

  assign lane_en = {~bhe_q, ~addr_q[0]};

  slv_regfile #(
    .ADDR_W     (ADDR_W),
    .IMPL_BYTES (IMPL_BYTES)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_en    (wr_launch),
    .word_idx (addr_q[ADDR_W-1:1]),
    .lane_en  (lane_en),
    .wdata    (din),
    .rdata    (rf_rdata)
  );

  always_comb begin
    dout_d = dout_q;
    if (rd_launch)    dout_d = rf_rdata;
    else if (cyc_end) dout_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) dout_q <= '0;
    else           dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/slv_bus_port_chk.sv
module slv_bus_port_chk
  import slv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             rd_smp,
  input logic             wr_smp,
  input logic             wr_en,
  input bus_state_e       state,
  input logic [BUS_W-1:0] dout,
  input logic             dout_oe,
  input logic             wait_o
);
  p_oe_in_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !wait_o);

  p_oe_launch_t3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(state) == ST_T2);

  p_stretch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T4 && dout_oe && !rd_n) |=> (dout_oe && $stable(dout) && !wait_o));

  p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  p_write_strobe_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!wr_n && !cs_n));

  p_idle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_o) |=> wait_o);

  p_conflict_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T1 && rd_smp && wr_smp) |=> (state == ST_TI && wait_o && !dout_oe));
endmodule

bind slv_bus_port slv_bus_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync),
  .cs_n    (cs_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .rd_smp  (rd_smp),
  .wr_smp  (wr_smp),
  .wr_en   (wr_launch),
  .state   (state),
  .dout    (dout),
  .dout_oe (dout_oe),
  .wait_o  (wait_o)
);

// File: tb/slv_bus_port_test.sv
`timescale 1ns/1ps
module slv_bus_port_test;
  localparam int IMPL = 192;

  logic        clk;
  logic        rst_n;
  logic        cs_n, rd_n, wr_n, bhe_n;
  logic [7:0]  addr;
  logic [15:0] din;
  logic [15:0] dout;
  logic        dout_oe, wait_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem_m [256];

  slv_bus_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bhe_n(bhe_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .wait_o(wait_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [7:0] a, input logic bhe);
    logic [7:0] ev, od;
    ev = {a[7:1], 1'b0};
    od = {a[7:1], 1'b1};
    if (int'(ev) >= IMPL) return 16'h0;
    return {(bhe ? 8'h00 : mem_m[od]), (a[0] ? 8'h00 : mem_m[ev])};
  endfunction

  task automatic model_write(input logic [7:0] a, input logic bhe, input logic [15:0] wd);
    logic [7:0] ev, od;
    ev = {a[7:1], 1'b0};
    od = {a[7:1], 1'b1};
    if (int'(ev) < IMPL) begin
      if (!a[0]) mem_m[ev] = wd[7:0];
      if (!bhe)  mem_m[od] = wd[15:8];
    end
  endtask

  // starts and ends in the drive slot (3 ns after a rising edge)
  task automatic bus_cycle(input bit is_wr, input logic [7:0] a, input logic bhe,
                           input logic [15:0] wd, input int stretch, input bit keep_cs,
                           input string tag);
    logic [15:0] expv;
    expv = model_read(a, bhe);
    cs_n = 1'b0; addr = a; bhe_n = bhe; din = wd;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    @(posedge clk); #1;                       // T1
    chk({"R7/R11 wait high in T1 ", tag}, {15'h0, wait_o}, 16'h1);
    chk({"R7 bus idle in T1 ", tag}, {15'h0, dout_oe}, 16'h0);
    #2; addr = 8'($urandom); bhe_n = 1'($urandom);   // R2: late address change
    @(posedge clk); #1;                       // T2
    chk({"R11 wait low in T2 ", tag}, {15'h0, wait_o}, 16'h0);
    chk({"R3 no drive in T2 ", tag}, {15'h0, dout_oe}, 16'h0);
    @(posedge clk); #1;                       // T3
    if (!is_wr) begin
      chk({"R3 oe at T3 ", tag}, {15'h0, dout_oe}, 16'h1);
      chk({"R2/R8/R9 read data ", tag}, dout, expv);
    end else begin
      chk({"R6 no drive on write ", tag}, {15'h0, dout_oe}, 16'h0);
    end
    #2; din = 16'($urandom);                  // R5: late data change
    @(posedge clk); #1;                       // T4
    chk({"R11 wait low in T4 ", tag}, {15'h0, wait_o}, 16'h0);
    for (int s = 0; s < stretch; s++) begin
      @(posedge clk); #1;
      chk({"R4 stretch wait ", tag}, {15'h0, wait_o}, 16'h0);
      if (!is_wr) chk({"R4 stretch data ", tag}, dout, expv);
    end
    #2; rd_n = 1'b1; wr_n = 1'b1;
    @(posedge clk); #1;                       // end edge
    chk({"R4/R6 wait back high ", tag}, {15'h0, wait_o}, 16'h1);
    chk({"R4 bus released ", tag}, {dout_oe, dout[14:0]}, 16'h0);
    if (is_wr) model_write(a, bhe, wd);
    #2;
    if (!keep_cs) cs_n = 1'b1;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic bhe, input string tag);
    bus_cycle(1'b0, a, bhe, 16'h0, 0, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; bhe_n = 1'b1;
    addr = 8'h00; din = 16'h0;
    repeat (4) @(posedge clk);
    #3; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset wait", {15'h0, wait_o}, 16'h1);
    chk("R1 reset oe", {15'h0, dout_oe}, 16'h0);
    chk("R1 reset dout", dout, 16'h0);
    #2;
    rd_check(8'h10, 1'b0, "R1 reset content");

    // R8 lanes
    bus_cycle(1'b1, 8'h20, 1'b0, 16'h1234, 0, 1'b0, "R8 word write");
    rd_check(8'h20, 1'b0, "R8 word read");
    bus_cycle(1'b1, 8'h20, 1'b1, 16'hAB55, 1, 1'b0, "R8 even byte write");
    bus_cycle(1'b1, 8'h21, 1'b0, 16'hCD77, 0, 1'b0, "R8 odd byte write");
    rd_check(8'h20, 1'b0, "R8 merged read");
    rd_check(8'h21, 1'b0, "R8 odd lane read");
    rd_check(8'h20, 1'b1, "R8 even lane read");
    bus_cycle(1'b1, 8'h21, 1'b1, 16'hFFFF, 0, 1'b0, "R8 no-lane write");
    rd_check(8'h21, 1'b1, "R8 no-lane read");
    rd_check(8'h20, 1'b0, "R8 after no-lane");

    // R9 unimplemented space
    bus_cycle(1'b1, 8'hC0, 1'b0, 16'hBEEF, 0, 1'b0, "R9 write C0");
    rd_check(8'hC0, 1'b0, "R9 read C0");
    bus_cycle(1'b1, 8'hBE, 1'b0, 16'h5AA5, 0, 1'b0, "R9 last word");
    rd_check(8'hBE, 1'b0, "R9 read BE");

    // R4 long stretch, R7 back to back with chip select held
    bus_cycle(1'b0, 8'h20, 1'b0, 16'h0, 5, 1'b1, "R4 long read");
    bus_cycle(1'b1, 8'h40, 1'b0, 16'h9876, 3, 1'b1, "R7 b2b write");
    bus_cycle(1'b0, 8'h40, 1'b0, 16'h0, 0, 1'b1, "R7 b2b read");
    bus_cycle(1'b0, 8'h20, 1'b0, 16'h0, 0, 1'b0, "R7 b2b read2");

    // R10 both strobes
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 8'h40; bhe_n = 1'b0; din = 16'hFFFF;
    @(posedge clk); #1;
    chk("R10 both T1 wait", {15'h0, wait_o}, 16'h1);
    #2; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 both wait", {15'h0, wait_o}, 16'h1);
    chk("R10 both oe", {15'h0, dout_oe}, 16'h0);
    @(posedge clk); #1;
    chk("R10 both still idle", {15'h0, wait_o}, 16'h1);
    #2;
    rd_check(8'h40, 1'b0, "R10 both no change");

    // R10 no strobe
    cs_n = 1'b0; addr = 8'h40; din = 16'h1111;
    @(posedge clk); #3; cs_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 none wait", {15'h0, wait_o}, 16'h1);
    chk("R10 none oe", {15'h0, dout_oe}, 16'h0);
    #2;
    rd_check(8'h40, 1'b0, "R10 none no change");

    // random mix: R2 R3 R5 R7 R8 R9
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ra;
      ra = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 64);
      bus_cycle(1'($urandom), ra, 1'($urandom), 16'($urandom), int'($urandom % 4),
                1'($urandom), "R5 random");
    end
    cs_n = 1'b1;
    for (int a = 0; a < 64; a += 2) rd_check(8'(a), 1'b0, "R5 final sweep");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule